// File: doc/BRIEF.md
# Dual-Channel PWM Counter Slice

This block is one pulse-width-modulation slice. A single free-running counter is shared by two compare channels, A and B. Each channel drives its pin high while the counter is below that channel's compare value, so the high time tracks the compare value. The counter runs in one of two shapes. In the sawtooth shape it climbs to a programmable ceiling and restarts at zero. In the triangle shape it climbs to the ceiling, descends back to zero and climbs again, which doubles the period and centres the pulses. The counter only moves on cycles where an external rate tick is high, so a clock divider outside the block sets the counting rate.

Software reaches the slice through a small write port with four targets: a control word, the ceiling, the packed pair of compare values, and the counter itself. While the slice runs, the ceiling and both compare values are held in shadow copies. They take effect only at the period boundary: the restart in sawtooth shape, or the arrival at zero in triangle shape. While the slice is stopped, a write takes effect at once. A one-shot nudge can add one count or swallow one count. Each request stays visible until it has acted. A one-cycle pulse marks every period boundary so that it can pace interrupts or DMA.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter reads 0, both pins and the boundary pulse are low, both nudge flags are clear, the control word is all zero and the ceiling is all ones (0xFFFF at the default width). Both compare values reset to 0.
- R2: In sawtooth shape (control bit 1 clear), each counting step moves the counter up by one. From a value at or above the active ceiling the step goes to 0 instead.
- R3: In triangle shape (control bit 1 set), the counter climbs to the ceiling, then steps down to 0 and turns upward again. Reaching 0 is the period boundary. With a ceiling of 3 and a start at 0, four steps leave the counter at 2 and six steps leave it at 0.
- R4: After each counting step, a pin's un-inverted level is 1 exactly when the new counter value is below that channel's active compare value. A compare value above the ceiling therefore holds the level high for the whole period.
- R5: Control bit 2 inverts pin A and control bit 3 inverts pin B. The change is visible in the cycle after the control write.
- R6: While running (control bit 0 set), writes to the ceiling (target 1) and to the compare pair (target 2: A in bits 15:0, B in bits 31:16) change only the shadow copies. Those copies become active at the next period boundary.
- R7: While stopped, a write to the ceiling or to a compare value becomes active at once.
- R8: A counting step happens on a cycle with the run bit set and the rate tick high. With the run bit clear the counter and both pins hold their values. Setting the bit again resumes from the held count.
- R9: Writing control bit 4 as 1 requests one extra step, and the advance flag reads 1 until the step is taken. The step is taken on the next cycle that is not already a running tick cycle. It also works while stopped, and the pins follow it as a normal step would.
- R10: Writing control bit 5 as 1 requests that one step be swallowed, and the retard flag reads 1 until then. The next running tick cycle is suppressed.
- R11: With ceiling, counter and compare values all 0, one running step leaves both pins low. The same sequence with compare A at 1 leaves pin A high.
- R12: The boundary pulse is high for exactly the one cycle after the step that ends a period, and the counter reads 0 in that cycle.
- R13: A counter write (target 3) loads the counter directly and suppresses any step in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 ceiling, 2 compare pair, 3 counter |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Rate tick from the external divider |
| pin_a | output | 1 | Channel A output |
| pin_b | output | 1 | Channel B output |
| wrap_pulse | output | 1 | One-cycle period-boundary marker |
| count | output | 16 | Current counter value |
| adv_busy | output | 1 | Advance request pending |
| ret_busy | output | 1 | Retard request pending |

## Verification
A tick or nudge acts on one rising edge. The new count, both pin levels and the boundary pulse all appear together one cycle after the inputs were presented. A register write is likewise visible one cycle after its strobe, and a polarity change shows on the pins in that same cycle. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It then compares every output against that model on the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks sample in that same cycle after counting out the ticks they issue.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TOP  = 2'd1,
    REG_CMP  = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;

  localparam int CTL_RUN   = 0;
  localparam int CTL_DUAL  = 1;
  localparam int CTL_INV_A = 2;
  localparam int CTL_INV_B = 3;
  localparam int CTL_ADV   = 4;
  localparam int CTL_RET   = 5;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dual,
  input  logic             tick,
  input  logic             adv_set,
  input  logic             ret_set,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_data,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             step_ev,
  output logic             wrap_ev,
  output logic             wrap_pulse,
  output logic             adv_busy,
  output logic             ret_busy
);

  localparam logic [CNT_W-1:0] TOP_RST = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  // Returns {next count, descending flag, period boundary}.
  function automatic logic [CNT_W+1:0] count_step(
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] t,
    input logic             down,
    input logic             tri_mode
  );
    logic [CNT_W+1:0] r;
    if (!tri_mode) begin
      if (c >= t) r = {{CNT_W{1'b0}}, 1'b0, 1'b1};
      else        r = {c + ONE, 1'b0, 1'b0};
    end else if (!down && (c < t)) begin
      r = {c + ONE, 1'b0, 1'b0};
    end else if (c <= ONE) begin
      r = {{CNT_W{1'b0}}, 1'b0, 1'b1};
    end else begin
      r = {c - ONE, 1'b1, 1'b0};
    end
    return r;
  endfunction

  logic             dir_q, adv_q, ret_q, wrap_q;
  logic [CNT_W-1:0] top_sh, top_act;
  logic             run_tick;
  logic [CNT_W+1:0] nx;

  assign run_tick = run & tick;
  assign step_ev  = ((run_tick & ~ret_q) | (adv_q & ~run_tick)) & ~cnt_wr;
  assign nx       = count_step(cnt_q, top_act, dir_q, dual);
  assign wrap_ev  = step_ev & nx[0];
  assign cnt_next = cnt_wr ? cnt_data : (step_ev ? nx[CNT_W+1:2] : cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      adv_q   <= 1'b0;
      ret_q   <= 1'b0;
      wrap_q  <= 1'b0;
      top_sh  <= TOP_RST;
      top_act <= TOP_RST;
    end else begin
      cnt_q  <= cnt_next;
      wrap_q <= wrap_ev;
      if (step_ev) dir_q <= nx[1];
      adv_q <= (adv_q & run_tick) | adv_set;
      ret_q <= (ret_q & ~run_tick) | ret_set;
      if (top_wr) top_sh <= top_data;
      if (top_wr && !run) top_act <= top_data;
      else if (wrap_ev)   top_act <= top_sh;
    end
  end

  assign wrap_pulse = wrap_q;
  assign adv_busy   = adv_q;
  assign ret_busy   = ret_q;

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (cnt_q == '0)); // R12
  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && !cnt_wr) |=> $stable(cnt_q)); // R8
  AST_ADV_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q && !run_tick && !adv_set) |=> !adv_q); // R9
  AST_RET_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q && run_tick && !ret_set) |=> !ret_q); // R10
  AST_CEIL_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_ev) |=> $stable(top_act)); // R6

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             invert,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             step_ev,
  input  logic             wrap_ev,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             pin
);

  function automatic logic level_of(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] k);
    return c < k;
  endfunction

  logic [CNT_W-1:0] cmp_sh, cmp_act, cmp_eff;
  logic             raw_q;

  assign cmp_eff = wrap_ev ? cmp_sh : cmp_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh  <= '0;
      cmp_act <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (cmp_wr) cmp_sh <= cmp_data;
      if (cmp_wr && !run) cmp_act <= cmp_data;
      else if (wrap_ev)   cmp_act <= cmp_sh;
      if (step_ev) raw_q <= level_of(cnt_next, cmp_eff);
    end
  end

  assign pin = raw_q ^ invert;

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !cmp_wr) |=> (raw_q == (cnt_q < cmp_act))); // R4
  AST_CMP_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_ev) |=> $stable(cmp_act)); // R6
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && $stable(invert)) |=> $stable(raw_q)); // R8

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [2*CNT_W-1:0] wr_data,
  input  logic               tick,
  output logic               pin_a,
  output logic               pin_b,
  output logic               wrap_pulse,
  output logic [CNT_W-1:0]   count,
  output logic               adv_busy,
  output logic               ret_busy
);

  reg_sel_e           sel;
  logic               run_q, dual_q;
  logic [NUM_CH-1:0]  inv_q, pins;
  logic               ctrl_wr, top_wr, cmp_wr, cnt_wr;
  logic [CNT_W-1:0]   cnt_q, cnt_next;
  logic               step_ev, wrap_ev;

  assign sel     = reg_sel_e'(wr_sel);
  assign ctrl_wr = wr_en && (sel == REG_CTRL);
  assign top_wr  = wr_en && (sel == REG_TOP);
  assign cmp_wr  = wr_en && (sel == REG_CMP);
  assign cnt_wr  = wr_en && (sel == REG_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dual_q <= 1'b0;
      inv_q  <= '0;
    end else if (ctrl_wr) begin
      run_q  <= wr_data[CTL_RUN];
      dual_q <= wr_data[CTL_DUAL];
      inv_q  <= {wr_data[CTL_INV_B], wr_data[CTL_INV_A]};
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .dual      (dual_q),
    .tick      (tick),
    .adv_set   (ctrl_wr && wr_data[CTL_ADV]),
    .ret_set   (ctrl_wr && wr_data[CTL_RET]),
    .top_wr    (top_wr),
    .top_data  (wr_data[CNT_W-1:0]),
    .cnt_wr    (cnt_wr),
    .cnt_data  (wr_data[CNT_W-1:0]),
    .cnt_q     (cnt_q),
    .cnt_next  (cnt_next),
    .step_ev   (step_ev),
    .wrap_ev   (wrap_ev),
    .wrap_pulse(wrap_pulse),
    .adv_busy  (adv_busy),
    .ret_busy  (ret_busy)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .invert  (inv_q[i]),
      .cmp_wr  (cmp_wr),
      .cmp_data(wr_data[i*CNT_W +: CNT_W]),
      .step_ev (step_ev),
      .wrap_ev (wrap_ev),
      .cnt_next(cnt_next),
      .cnt_q   (cnt_q),
      .pin     (pins[i])
    );
  end

  assign pin_a = pins[0];
  assign pin_b = pins[1];
  assign count = cnt_q;

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data[CNT_W-1:0]))); // R13

endmodule

// File: tb/pwm_slice_test.sv
module pwm_slice_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        tick = 1'b0;
  logic        pin_a, pin_b, wrap_pulse, adv_busy, ret_busy;
  logic [15:0] count;

  always #5 clk = ~clk;

  pwm_slice uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .pin_a(pin_a), .pin_b(pin_b), .wrap_pulse(wrap_pulse),
    .count(count), .adv_busy(adv_busy), .ret_busy(ret_busy)
  );

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_top, m_top_s, m_ca, m_ca_s, m_cb, m_cb_s;
  bit m_down, m_run, m_dual, m_inva, m_invb, m_adv, m_ret, m_ra, m_rb, m_wrap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_top = 65535; m_top_s = 65535;
      m_ca = 0; m_ca_s = 0; m_cb = 0; m_cb_s = 0;
      m_down = 0; m_run = 0; m_dual = 0; m_inva = 0; m_invb = 0;
      m_adv = 0; m_ret = 0; m_ra = 0; m_rb = 0; m_wrap = 0;
    end else begin
      bit rt, stp, w;
      rt  = m_run && tick;
      stp = ((rt && !m_ret) || (m_adv && !rt)) && !(wr_en && wr_sel == 2'd3);
      if (m_adv && !rt) m_adv = 0;
      if (rt && m_ret) m_ret = 0;
      w = 0;
      if (stp) begin
        if (!m_dual) begin
          m_down = 0;
          if (m_cnt >= m_top) begin m_cnt = 0; w = 1; end
          else m_cnt = m_cnt + 1;
        end else if (!m_down && m_cnt < m_top) begin
          m_cnt = m_cnt + 1;
        end else if (m_cnt <= 1) begin
          m_cnt = 0; m_down = 0; w = 1;
        end else begin
          m_cnt = m_cnt - 1; m_down = 1;
        end
        if (w) begin m_top = m_top_s; m_ca = m_ca_s; m_cb = m_cb_s; end
        m_ra = (m_cnt < m_ca);
        m_rb = (m_cnt < m_cb);
      end
      m_wrap = w;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            m_run = wr_data[0]; m_dual = wr_data[1];
            m_inva = wr_data[2]; m_invb = wr_data[3];
            if (wr_data[4]) m_adv = 1;
            if (wr_data[5]) m_ret = 1;
          end
          2'd1: begin
            m_top_s = int'(wr_data[15:0]);
            if (!m_run) m_top = m_top_s;
          end
          2'd2: begin
            m_ca_s = int'(wr_data[15:0]); m_cb_s = int'(wr_data[31:16]);
            if (!m_run) begin m_ca = m_ca_s; m_cb = m_cb_s; end
          end
          default: m_cnt = int'(wr_data[15:0]);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 pin_a vs model", int'(pin_a), int'(m_ra ^ m_inva));
      chk("R4 pin_b vs model", int'(pin_b), int'(m_rb ^ m_invb));
      chk("R12 wrap_pulse vs model", int'(wrap_pulse), int'(m_wrap));
      chk("R2 count vs model", int'(count), m_cnt);
      chk("R9 adv_busy vs model", int'(adv_busy), int'(m_adv));
      chk("R10 ret_busy vs model", int'(ret_busy), int'(m_ret));
    end
  end

  task automatic wr(input int sel, input int unsigned data);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data; tick = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  localparam int RUN = 1, DUAL = 2, INVA = 4, ADV = 16, RET = 32;

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a0, b0, c0, lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 pin_a", int'(pin_a), 0);
    chk("R1 pin_b", int'(pin_b), 0);
    chk("R1 wrap", int'(wrap_pulse), 0);
    chk("R1 busy", int'(adv_busy | ret_busy), 0);
    // R1 ceiling resets to all ones, R13 counter load
    wr(3, 32'hFFFE);
    chk("R13 count load", int'(count), 16'hFFFE);
    wr(0, RUN);
    tick_n(2);
    chk("R1 reset ceiling wraps after FFFF", int'(count), 0);
    chk("R12 pulse at boundary", int'(wrap_pulse), 1);
    @(negedge clk);
    chk("R12 pulse lasts one cycle", int'(wrap_pulse), 0);
    // R7 stopped writes immediate, R4 levels
    wr(0, 0);
    wr(1, 4);
    wr(2, (5 << 16) | 2);
    wr(3, 0);
    wr(0, RUN);
    tick_n(3);
    chk("R7 count", int'(count), 3);
    chk("R4 pin_a low at/after compare", int'(pin_a), 0);
    chk("R4 pin_b high, compare above ceiling", int'(pin_b), 1);
    // R6 shadowed compare
    wr(2, (5 << 16) | 4);
    tick_n(1);
    chk("R6 count at ceiling", int'(count), 4);
    chk("R6 old compare still active", int'(pin_a), 0);
    tick_n(1);
    chk("R2 wrap to zero", int'(count), 0);
    chk("R6 new compare after boundary", int'(pin_a), 1);
    // R6 shadowed ceiling
    wr(1, 2);
    tick_n(3);
    chk("R6 old ceiling still active", int'(count), 3);
    tick_n(2);
    tick_n(3);
    chk("R6 new ceiling after boundary", int'(count), 0);
    // R5 inversion
    a0 = int'(pin_a); b0 = int'(pin_b);
    wr(0, RUN | INVA);
    chk("R5 pin_a inverted", int'(pin_a), 1 - a0);
    chk("R5 pin_b untouched", int'(pin_b), b0);
    // R8 freeze and resume
    wr(0, INVA);
    c0 = int'(count); a0 = int'(pin_a); b0 = int'(pin_b);
    tick_n(5);
    chk("R8 frozen count", int'(count), c0);
    chk("R8 frozen pin_a", int'(pin_a), a0);
    chk("R8 frozen pin_b", int'(pin_b), b0);
    wr(0, RUN | INVA);
    tick_n(1);
    chk("R8 resume", int'(count), c0 + 1);
    // R9 advance while stopped
    wr(0, INVA);
    wr(0, INVA | ADV);
    chk("R9 advance pending", int'(adv_busy), 1);
    chk("R9 no step yet", int'(count), 1);
    @(negedge clk);
    chk("R9 advance applied", int'(count), 2);
    chk("R9 advance retired", int'(adv_busy), 0);
    // R10 retard
    wr(0, RUN | INVA | RET);
    chk("R10 retard pending", int'(ret_busy), 1);
    tick_n(3);
    chk("R10 one tick swallowed", int'(count), 1);
    chk("R10 retard retired", int'(ret_busy), 0);
    // R11 zero ceiling / counter / compare
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    wr(0, RUN); tick_n(1); wr(0, 0);
    chk("R11 pin_a low", int'(pin_a), 0);
    chk("R11 pin_b low", int'(pin_b), 0);
    wr(2, 1);
    wr(0, RUN); tick_n(1); wr(0, 0);
    chk("R11 pin_a high with compare 1", int'(pin_a), 1);
    chk("R11 pin_b still low", int'(pin_b), 0);
    // R3 triangle shape
    wr(1, 3); wr(3, 0);
    wr(0, RUN | DUAL);
    tick_n(4);
    chk("R3 descending", int'(count), 2);
    tick_n(2);
    chk("R3 reaches zero", int'(count), 0);
    chk("R3 boundary pulse", int'(wrap_pulse), 1);
    tick_n(8);
    chk("R3 second period", int'(count), 2);
    // Mixed stimulus, checked every cycle against the model
    wr(1, 5);
    lf = 32'h1ACE;
    for (int k = 0; k < 600; k++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
      tick = lf[3] | lf[5];
      wr_en = 1'b0;
      if ((lf & 32'h1F0) == 32'h030) begin
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = ((lf >> 8) & 7) << 16 | ((lf >> 12) & 7);
      end else if ((lf & 32'h1F0) == 32'h050) begin
        wr_en = 1'b1; wr_sel = 2'd0;
        wr_data = RUN | (k < 300 ? DUAL : 0) | (lf[9] ? ADV : 0) | (lf[10] ? RET : 0);
      end else if ((lf & 32'h1F0) == 32'h070) begin
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 2 + ((lf >> 11) & 3);
      end
      @(negedge clk);
    end
    wr_en = 1'b0; tick = 1'b0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule